// File: doc/BRIEF.md
# Bank-to-Bank Block Move Engine

This block is a byte-copy sequencer. Software-visible parameters arrive on a start pulse. A source bank byte and a 16-bit source index (X) form the read address. A destination bank byte and a 16-bit destination index (Y) form the write address. A 16-bit count register (C) holds the number of bytes to move, minus one. A direction input chooses whether the indexes climb or fall after each byte.

The engine talks to memory over one synchronous port. It issues a read, holds it until the memory accepts it with `mem_ready`, and then writes the captured byte to the destination, again waiting for `mem_ready`. After each completed write it steps X and Y and decrements C. The move ends after the byte on which C wraps from 0000 to FFFF.

When a move starts, the data bank register output is overwritten with the destination bank. A narrow-index mode keeps X and Y to eight bits, so the copy stays inside offsets 00 to FF of each bank. A pause input stands in for preemption by an interrupt: it takes effect only between complete read/write pairs, and it leaves X, Y and C ready for the move to resume.

Top module: `bank_move_engine`

## Requirements
- R1: After reset, `busy`, `done`, `paused` and `mem_req` are 0, and `dbr_out`, `x_out`, `y_out` and `cnt_out` are 0.
- R2: A `start` pulse while idle latches the parameters and makes `busy` 1 and `dbr_out` equal to `dst_bank` on the next cycle. A `start` pulse while busy has no effect on the move in progress or on `dbr_out`.
- R3: Each byte is one read at address {`src_bank`, X} with `mem_we`=0. It is followed by one write at address {`dst_bank`, Y} with `mem_we`=1, and `mem_wdata` equals the byte read. Address bits 23:16 carry the bank and bits 15:0 carry the index.
- R4: A request (`mem_req`=1) whose `mem_ready` is 0 is repeated on the next cycle with the same address and the same `mem_we`. A transfer completes on a clock edge where `mem_req` and `mem_ready` are both 1.
- R5: With `descend`=0, X and Y increase by one after each completed write. With `descend`=1, they decrease by one. Both wrap modulo 2^16, and the bank bytes never change during a move.
- R6: C decreases by one after each completed write. The move copies C+1 bytes and ends after the byte on which C wraps from 0000 to FFFF, so `cnt_out` reads FFFF at the end.
- R7: With `narrow`=1 at start, the high bytes of X and Y are loaded as 00, and stepping wraps within 00 to FF while the high byte stays 00.
- R8: `pause` is sampled only on the edge that completes a write of a byte that is not the last one. It then stops all requests and holds X, Y and C, with `paused`=1, until `pause` falls. A read that has started always finishes together with its write.
- R9: `done` is 1 for exactly one cycle, the cycle after the final write completes. In that cycle `busy` and `paused` are 0, even if `pause` was high on the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move with the parameters below |
| descend | input | 1 | 1 = indexes decrement, 0 = increment |
| narrow | input | 1 | 1 = eight-bit indexes |
| dst_bank | input | 8 | Destination bank byte |
| src_bank | input | 8 | Source bank byte |
| x_init | input | 16 | Initial source index |
| y_init | input | 16 | Initial destination index |
| cnt_init | input | 16 | Byte count minus one |
| pause | input | 1 | Preemption request, honoured between bytes |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Memory address {bank, index} |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current request |
| busy | output | 1 | Move in progress, including a pause |
| done | output | 1 | One-cycle end-of-move pulse |
| paused | output | 1 | Move held by `pause` |
| dbr_out | output | 8 | Data bank register |
| x_out | output | 16 | Current source index |
| y_out | output | 16 | Current destination index |
| cnt_out | output | 16 | Current count register |

## Verification
The delicate cycle is the one where a completed write of the last byte meets a pause request. On that edge the engine must end the move and not enter the hold state. The bench provokes this by starting a one-byte move with `pause` already high. It requires `done`=1 with `paused`=0 on the following cycle and no further requests. A second overlap, a `start` arriving mid-move, is provoked by pulsing `start` with different banks during a transfer. It is judged by the address stream and `dbr_out`, which must continue to match the original move.

// File: rtl/bank_move_pkg.sv
package bank_move_pkg;
    localparam int unsigned BANK_BITS  = 8;
    localparam int unsigned INDEX_BITS = 16;
    localparam int unsigned BYTE_BITS  = 8;
    localparam int unsigned NARROW_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_HOLD  = 2'd3
    } move_state_e;
endpackage

// File: rtl/bank_move_idx_step.sv
module bank_move_idx_step #(
    parameter int unsigned IDX_W    = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic [IDX_W-1:0] cur,
    input  logic             descend,
    input  logic             narrow,
    output logic [IDX_W-1:0] nxt
);
    logic [IDX_W-1:0] wide_nxt;

    always_comb begin
        wide_nxt = descend ? (cur - 1'b1) : (cur + 1'b1);
    end

    generate
        if (NARROW_W < IDX_W) begin : g_narrow
            logic [NARROW_W-1:0] low_nxt;
            always_comb begin
                low_nxt = descend ? (cur[NARROW_W-1:0] - 1'b1)
                                  : (cur[NARROW_W-1:0] + 1'b1);
                nxt = narrow ? {{(IDX_W-NARROW_W){1'b0}}, low_nxt} : wide_nxt;
            end
        end else begin : g_wide_only
            always_comb begin
                nxt = wide_nxt | {IDX_W{1'b0 & narrow}};
            end
        end
    endgenerate
endmodule

// File: rtl/bank_move_count.sv
module bank_move_count #(
    parameter int unsigned IDX_W = 16
) (
    input  logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] nxt,
    output logic             last
);
    always_comb begin
        nxt  = cur - 1'b1;
        last = (cur == '0);
    end
endmodule

// File: rtl/bank_move_ctrl.sv
module bank_move_ctrl
    import bank_move_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pause,
    input  logic mem_ready,
    input  logic last,
    output logic load,
    output logic capture,
    output logic step,
    output logic mem_req,
    output logic mem_we,
    output logic busy,
    output logic done,
    output logic paused
);
    typedef struct packed {
        move_state_e state;
        logic        done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        load        = 1'b0;
        capture     = 1'b0;
        step        = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start) begin
                    load         = 1'b1;
                    ctrl_d.state = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    capture      = 1'b1;
                    ctrl_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    step = 1'b1;
                    if (last) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.done  = 1'b1;
                    end else if (pause) begin
                        ctrl_d.state = ST_HOLD;
                    end else begin
                        ctrl_d.state = ST_READ;
                    end
                end
            end
            ST_HOLD: begin
                if (!pause) ctrl_d.state = ST_READ;
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.done  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mem_req = (ctrl_q.state == ST_READ) || (ctrl_q.state == ST_WRITE);
    assign mem_we  = (ctrl_q.state == ST_WRITE);
    assign busy    = (ctrl_q.state != ST_IDLE);
    assign paused  = (ctrl_q.state == ST_HOLD);
    assign done    = ctrl_q.done;

    // R4: an unaccepted request is repeated with the same direction
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)));

    // R8: the hold state is only entered from a completed write
    assert_pause_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> ($past(ctrl_q.state) == ST_WRITE || $past(ctrl_q.state) == ST_HOLD));

    // R9: done is a single-cycle pulse, seen only when idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !paused));
endmodule

// File: rtl/bank_move_engine.sv
module bank_move_engine
    import bank_move_pkg::*;
#(
    parameter int unsigned BANK_W   = BANK_BITS,
    parameter int unsigned IDX_W    = INDEX_BITS,
    parameter int unsigned DATA_W   = BYTE_BITS,
    parameter int unsigned NARROW_W = NARROW_BITS,
    localparam int unsigned ADDR_W  = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              descend,
    input  logic              narrow,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [IDX_W-1:0]  x_init,
    input  logic [IDX_W-1:0]  y_init,
    input  logic [IDX_W-1:0]  cnt_init,
    input  logic              pause,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              paused,
    output logic [BANK_W-1:0] dbr_out,
    output logic [IDX_W-1:0]  x_out,
    output logic [IDX_W-1:0]  y_out,
    output logic [IDX_W-1:0]  cnt_out
);
    typedef struct packed {
        logic [BANK_W-1:0] src_bank;
        logic [BANK_W-1:0] dst_bank;
        logic [BANK_W-1:0] dbr;
        logic [IDX_W-1:0]  x;
        logic [IDX_W-1:0]  y;
        logic [IDX_W-1:0]  cnt;
        logic [DATA_W-1:0] dbuf;
        logic              desc;
        logic              nar;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             load, capture, step, last;
    logic [IDX_W-1:0] x_step, y_step, cnt_step;
    logic [IDX_W-1:0] x_load, y_load;

    bank_move_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pause     (pause),
        .mem_ready (mem_ready),
        .last      (last),
        .load      (load),
        .capture   (capture),
        .step      (step),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done),
        .paused    (paused)
    );

    bank_move_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) u_x_step (
        .cur (dp_q.x), .descend (dp_q.desc), .narrow (dp_q.nar), .nxt (x_step)
    );

    bank_move_idx_step #(.IDX_W(IDX_W), .NARROW_W(NARROW_W)) u_y_step (
        .cur (dp_q.y), .descend (dp_q.desc), .narrow (dp_q.nar), .nxt (y_step)
    );

    bank_move_count #(.IDX_W(IDX_W)) u_count (
        .cur (dp_q.cnt), .nxt (cnt_step), .last (last)
    );

    generate
        if (NARROW_W < IDX_W) begin : g_load_mask
            always_comb begin
                x_load = narrow ? {{(IDX_W-NARROW_W){1'b0}}, x_init[NARROW_W-1:0]} : x_init;
                y_load = narrow ? {{(IDX_W-NARROW_W){1'b0}}, y_init[NARROW_W-1:0]} : y_init;
            end
        end else begin : g_load_plain
            always_comb begin
                x_load = x_init;
                y_load = y_init;
            end
        end
    endgenerate

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.src_bank = src_bank;
            dp_d.dst_bank = dst_bank;
            dp_d.dbr      = dst_bank;
            dp_d.x        = x_load;
            dp_d.y        = y_load;
            dp_d.cnt      = cnt_init;
            dp_d.desc     = descend;
            dp_d.nar      = narrow;
        end
        if (capture) begin
            dp_d.dbuf = mem_rdata;
        end
        if (step) begin
            dp_d.x   = x_step;
            dp_d.y   = y_step;
            dp_d.cnt = cnt_step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr  = mem_we ? {dp_q.dst_bank, dp_q.y} : {dp_q.src_bank, dp_q.x};
    assign mem_wdata = dp_q.dbuf;
    assign dbr_out   = dp_q.dbr;
    assign x_out     = dp_q.x;
    assign y_out     = dp_q.y;
    assign cnt_out   = dp_q.cnt;

    // R4: address held while the memory has not accepted
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> $stable(mem_addr));

    // R2: data bank register tracks the destination bank of the active move
    assert_dbr_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dbr_out == dp_q.dst_bank));

    // R7: high index bytes stay clear in narrow mode
    assert_narrow_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dp_q.nar) |-> (x_out[IDX_W-1:NARROW_W] == '0 && y_out[IDX_W-1:NARROW_W] == '0));

    // R6: each completed byte lowers the count by one
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_out == $past(cnt_out) - 1'b1));

    // R8: registers are frozen while held
    assert_hold_regs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> ($stable(x_out) && $stable(y_out) && $stable(cnt_out)));
endmodule

// File: tb/bank_move_engine_test.sv
module bank_move_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, descend = 1'b0, narrow = 1'b0, pause = 1'b0;
    logic [7:0]  dst_bank = '0, src_bank = '0;
    logic [15:0] x_init = '0, y_init = '0, cnt_init = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, paused;
    logic [7:0]  dbr_out;
    logic [15:0] x_out, y_out, cnt_out;

    int checks = 0, errors = 0, moves = 0;
    logic [15:0] ex, ey, ec;
    logic [7:0]  m_src, m_dst, rd_exp;
    logic        m_desc, m_nar, exp_done = 1'b0, rdy_on = 1'b0;
    int          seed_sink;

    always #5 clk = ~clk;

    bank_move_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .descend(descend), .narrow(narrow),
        .dst_bank(dst_bank), .src_bank(src_bank), .x_init(x_init), .y_init(y_init),
        .cnt_init(cnt_init), .pause(pause), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .paused(paused),
        .dbr_out(dbr_out), .x_out(x_out), .y_out(y_out), .cnt_out(cnt_out)
    );

    function automatic logic [7:0] pattern(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] step_idx(input logic [15:0] v, input logic dn, input logic nr);
        logic [15:0] w;
        logic [7:0]  b;
        w = dn ? v - 16'd1 : v + 16'd1;
        b = dn ? v[7:0] - 8'd1 : v[7:0] + 8'd1;
        return nr ? {8'h00, b} : w;
    endfunction

    assign mem_rdata = pattern(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    // memory responder and reference model of the address stream
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = rdy_on && (($urandom % 4) != 0);
            #1;
            if (exp_done) begin
                chk(done && !busy && !paused, "R9 done pulse", {busy, paused, done}, 3'b001);
                chk(cnt_out == 16'hFFFF, "R6 final count", cnt_out, 16'hFFFF);
                chk(x_out == ex && y_out == ey, "R5 final index", {x_out, y_out}, {ex, ey});
                exp_done = 1'b0;
                moves++;
            end else if (done) begin
                chk(1'b0, "R9 unexpected done", done, 1'b0);
            end
            if (mem_req && mem_ready) begin
                if (!mem_we) begin
                    chk(mem_addr == {m_src, ex}, "R3 read address", mem_addr, {m_src, ex});
                    rd_exp = pattern(mem_addr);
                end else begin
                    chk(mem_addr == {m_dst, ey} && mem_wdata == rd_exp, "R3 write address/data",
                        {mem_wdata, mem_addr}, {rd_exp, m_dst, ey});
                    if (ec == 16'h0000) exp_done = 1'b1;
                    ex = step_idx(ex, m_desc, m_nar);
                    ey = step_idx(ey, m_desc, m_nar);
                    ec = ec - 16'd1;
                end
            end
        end
    end

    task automatic begin_move(input logic [7:0] s, input logic [7:0] d, input logic [15:0] x,
                              input logic [15:0] y, input logic [15:0] c, input logic dn, input logic nr);
        @(negedge clk);
        src_bank = s; dst_bank = d; x_init = x; y_init = y; cnt_init = c;
        descend = dn; narrow = nr; start = 1'b1;
        m_src = s; m_dst = d; m_desc = dn; m_nar = nr; ec = c;
        ex = nr ? {8'h00, x[7:0]} : x;
        ey = nr ? {8'h00, y[7:0]} : y;
        @(negedge clk);
        start = 1'b0;
        #2;
        chk(busy && dbr_out == d, "R2 start loads bank", {busy, dbr_out}, {1'b1, d});
    endtask

    task automatic wait_move(input int m0);
        for (int i = 0; i < 6000 && moves == m0; i++) begin
            @(negedge clk); #2;
        end
        chk(moves > m0, "R6 move completion", moves, m0 + 1);
    endtask

    task automatic move(input logic [7:0] s, input logic [7:0] d, input logic [15:0] x,
                        input logic [15:0] y, input logic [15:0] c, input logic dn, input logic nr);
        int m0;
        m0 = moves;
        begin_move(s, d, x, y, c, dn, nr);
        wait_move(m0);
    endtask

    initial begin
        int m0;
        logic [15:0] c0;
        seed_sink = $urandom(32'h00C0FFEE);
        repeat (3) @(negedge clk);
        #2;
        chk(!busy && !done && !paused && !mem_req, "R1 reset controls",
            {busy, done, paused, mem_req}, 4'b0000);
        chk(dbr_out == 8'h00 && x_out == 16'h0 && y_out == 16'h0 && cnt_out == 16'h0,
            "R1 reset registers", {dbr_out, x_out}, 24'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rdy_on = 1'b1;

        // directed corners
        move(8'h12, 8'h34, 16'h1000, 16'h2000, 16'h0000, 1'b0, 1'b0);      // single byte, R6
        move(8'h01, 8'h02, 16'hFFFE, 16'hFFFD, 16'h0004, 1'b0, 1'b0);      // R5 ascending wrap
        move(8'hA0, 8'hB0, 16'h0001, 16'h0002, 16'h0005, 1'b1, 1'b0);      // R5 descending wrap
        move(8'h07, 8'h08, 16'h12FD, 16'h34FE, 16'h0006, 1'b0, 1'b1);      // R7 narrow wrap up
        chk(x_out[15:8] == 8'h00 && y_out[15:8] == 8'h00, "R7 narrow high byte", {x_out, y_out}, 32'h0);
        move(8'h09, 8'h0A, 16'h5501, 16'h6600, 16'h0003, 1'b1, 1'b1);      // R7 narrow wrap down

        // R2: start while busy is ignored
        m0 = moves;
        begin_move(8'h40, 8'h41, 16'h0100, 16'h0200, 16'h0009, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        start = 1'b1; src_bank = 8'hEE; dst_bank = 8'hDD; x_init = 16'h7777; cnt_init = 16'h0;
        @(negedge clk);
        start = 1'b0;
        #2;
        chk(dbr_out == 8'h41 && busy, "R2 start while busy", dbr_out, 8'h41);
        wait_move(m0);
        chk(dbr_out == 8'h41, "R2 bank kept after ignored start", dbr_out, 8'h41);

        // R8: pause held from start: one pair completes, then hold
        pause = 1'b1;
        c0 = 16'h0007;
        m0 = moves;
        begin_move(8'h20, 8'h30, 16'h0400, 16'h0500, c0, 1'b0, 1'b0);
        for (int i = 0; i < 200 && !paused; i++) begin
            @(negedge clk); #2;
        end
        chk(paused && !mem_req, "R8 hold entered", {paused, mem_req}, 2'b10);
        chk(cnt_out == c0 - 16'd1 && x_out == 16'h0401 && y_out == 16'h0501, "R8 one pair before hold",
            {cnt_out, x_out}, {c0 - 16'd1, 16'h0401});
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #2;
            chk(!mem_req && paused && x_out == 16'h0401 && cnt_out == c0 - 16'd1,
                "R8 quiet while held", {mem_req, x_out}, {1'b0, 16'h0401});
        end
        pause = 1'b0;
        wait_move(m0);

        // R8/R9 overlap: pause high on the final byte must finish, not hold
        pause = 1'b1;
        m0 = moves;
        begin_move(8'h55, 8'h66, 16'h0010, 16'h0020, 16'h0000, 1'b0, 1'b0);
        wait_move(m0);
        @(negedge clk); #2;
        chk(!paused && !busy && !mem_req, "R9 final byte ignores pause", {paused, busy, mem_req}, 3'b000);
        pause = 1'b0;

        // constrained random moves
        for (int n = 0; n < 24; n++) begin
            logic [15:0] rx, ry;
            rx = $urandom;
            ry = $urandom;
            if (n % 4 == 0) rx = 16'hFFF8 + 16'($urandom % 8);
            if (n % 4 == 1) ry = 16'($urandom % 6);
            move(8'($urandom), 8'($urandom), rx, ry, 16'($urandom % 24), 1'($urandom), 1'($urandom));
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule